// File: doc/BRIEF.md
# Flash Command Window Sequencer

This block sits on the host side of a memory-mapped flash command window. It takes one request, carrying a command code, a target address, a byte count that may be zero and an optional data word. It turns that request into a fixed series of single-word writes on a plain write bus, and each write waits for the bus to accept it. The series ends with a start-execution write. After that the block polls the window's status word through a read port until the device reports ready.

When the ready status arrives, the block gives a one-cycle done pulse. With the pulse it returns the status word it read and an error flag derived from that word. The window's base address on the bus is a parameter. The register offsets inside the window are fixed, because the device decodes them. A request is taken only while the block is idle and only when it carries a known command code. Any other request is dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `rd_valid` and `done` are all 0.
- R2: The first write of an accepted request goes to base+0x80 and carries the command code, zero-extended to the bus width.
- R3: The next two writes carry the target address. The first goes to base+0x88 with the address modulo 2^W. The second goes to base+0x8A with the address shifted right by W, where W is the bus data width.
- R4: When the byte count is nonzero, two writes follow the address. The first goes to base+0x90 with the count modulo 2^W. The second goes to base+0x92 with the count shifted right by W. When the count is zero, neither write is made.
- R5: When `req_has_data` is 1, `req_data` is written to base+0x84 after the count step. When `req_has_data` is 0, this write is omitted.
- R6: Every command ends with a write of 0x0001 to base+0xC0, and no further writes follow it.
- R7: A write is complete only in a cycle where `wr_valid` and `wr_ready` are both 1. Until that cycle, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R8: After the execute write, reads are made at base+0xCC, one after another, until a returned word has bit 7 set (1 = ready, 0 = busy). A read is complete when `rd_valid` and `rd_ready` are both 1. The read address holds until then, and a write and a read are never requested in the same cycle.
- R9: One cycle after the ready read completes, `done` is 1 for exactly one cycle. In that cycle `status` equals the ready word, and `err` is 1 exactly when that word ANDed with 0x133A is nonzero.
- R10: Requests are ignored while `busy` is 1. A request whose code is not one of 0x41, 0xE9, 0x20, 0x61, 0x62, 0x65, 0x98, 0x97, 0xC0 or 0xD0 is ignored: no writes are made and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_cmd | input | 8 | Command code |
| req_addr | input | TGT_W | Target address |
| req_count | input | CNT_W | Byte count; 0 means no count writes |
| req_has_data | input | 1 | A data word comes with the request |
| req_data | input | DATA_W | Data word |
| busy | output | 1 | A command is in progress |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write bus address |
| wr_data | output | DATA_W | Write bus data |
| wr_ready | input | 1 | Write accepted this cycle |
| rd_valid | output | 1 | Status read request |
| rd_addr | output | ADDR_W | Status read address |
| rd_ready | input | 1 | Read completes this cycle |
| rd_data | input | DATA_W | Read data, valid with rd_ready |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error bits were set in the final status |
| status | output | DATA_W | Final status word |

## Verification
A wrong step register shows up at the write bus within the same command. The symptoms are a write at an unexpected offset, a skipped or repeated word, or extra writes after the execute write. The bench flags such a write at the handshake where it happens. A broken hold or poll loop shows at the next cycle, as a changed address or data while the handshake is pending, or as a done pulse that comes too early or is missing. A fault in the captured request or in the status logic shows as a wrong word on one of the writes, or as a wrong `status` or `err` in the done cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADRL, ST_ADRH, ST_CNTL, ST_CNTH, ST_DATA, ST_EXEC, ST_POLL
  } step_e;

  localparam logic [7:0] OFF_CMD  = 8'h80;
  localparam logic [7:0] OFF_DATA = 8'h84;
  localparam logic [7:0] OFF_ADRL = 8'h88;
  localparam logic [7:0] OFF_ADRH = 8'h8A;
  localparam logic [7:0] OFF_CNTL = 8'h90;
  localparam logic [7:0] OFF_CNTH = 8'h92;
  localparam logic [7:0] OFF_EXEC = 8'hC0;
  localparam logic [7:0] OFF_STAT = 8'hCC;

  localparam logic [15:0] ERR_MASK  = 16'h133A;
  localparam int          READY_BIT = 7;

  function automatic logic cmd_known(input logic [7:0] c);
    case (c)
      8'h41, 8'hE9, 8'h20, 8'h61, 8'h62,
      8'h65, 8'h98, 8'h97, 8'hC0, 8'hD0: cmd_known = 1'b1;
      default:                          cmd_known = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fcw_step_ctrl.sv
module fcw_step_ctrl
  import flash_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  has_cnt,
  input  logic  has_data,
  input  logic  wr_fire,
  input  logic  rd_fire,
  input  logic  rd_is_ready,
  output step_e step
);

  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_IDLE: if (start) step_d = ST_CMD;
      ST_CMD:  if (wr_fire) step_d = ST_ADRL;
      ST_ADRL: if (wr_fire) step_d = ST_ADRH;
      ST_ADRH: if (wr_fire) step_d = has_cnt ? ST_CNTL : (has_data ? ST_DATA : ST_EXEC);
      ST_CNTL: if (wr_fire) step_d = ST_CNTH;
      ST_CNTH: if (wr_fire) step_d = has_data ? ST_DATA : ST_EXEC;
      ST_DATA: if (wr_fire) step_d = ST_EXEC;
      ST_EXEC: if (wr_fire) step_d = ST_POLL;
      ST_POLL: if (rd_fire && rd_is_ready) step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  assign step = step_q;

  // R8: a busy status read keeps the poll going
  p_keep_polling_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_POLL && !(rd_fire && rd_is_ready)) |=> step_q == ST_POLL);

  // R10: a start while idle always leads to the command write
  p_start_to_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_IDLE && start) |=> step_q == ST_CMD);

endmodule

// File: rtl/fcw_word_mux.sv
module fcw_word_mux
  import flash_cmd_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              TGT_W    = 32,
  parameter int              CNT_W    = 32,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [7:0]        cmd_in,
  input  logic [TGT_W-1:0]  addr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              has_data_in,
  input  logic [DATA_W-1:0] data_in,
  input  step_e             step,
  output logic              has_cnt,
  output logic              has_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr
);

  logic [7:0]        cmd_q;
  logic [TGT_W-1:0]  addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_nz_q, has_data_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      addr_q     <= '0;
      cnt_q      <= '0;
      cnt_nz_q   <= 1'b0;
      has_data_q <= 1'b0;
      data_q     <= '0;
    end else if (load) begin
      cmd_q      <= cmd_in;
      addr_q     <= addr_in;
      cnt_q      <= cnt_in;
      cnt_nz_q   <= (cnt_in != '0);
      has_data_q <= has_data_in;
      data_q     <= data_in;
    end
  end

  logic [DATA_W-1:0] addr_lo, addr_hi, cnt_lo, cnt_hi;
  assign addr_lo = addr_q[DATA_W-1:0];
  assign addr_hi = DATA_W'(addr_q[TGT_W-1:DATA_W]);
  assign cnt_lo  = cnt_q[DATA_W-1:0];
  assign cnt_hi  = DATA_W'(cnt_q[CNT_W-1:DATA_W]);

  logic [7:0] off;
  always_comb begin
    off     = OFF_CMD;
    wr_data = '0;
    case (step)
      ST_CMD:  begin off = OFF_CMD;  wr_data = DATA_W'(cmd_q); end
      ST_ADRL: begin off = OFF_ADRL; wr_data = addr_lo; end
      ST_ADRH: begin off = OFF_ADRH; wr_data = addr_hi; end
      ST_CNTL: begin off = OFF_CNTL; wr_data = cnt_lo; end
      ST_CNTH: begin off = OFF_CNTH; wr_data = cnt_hi; end
      ST_DATA: begin off = OFF_DATA; wr_data = data_q; end
      ST_EXEC: begin off = OFF_EXEC; wr_data = DATA_W'(1); end
      default: begin off = OFF_CMD;  wr_data = '0; end
    endcase
  end

  assign wr_addr  = WIN_BASE + ADDR_W'(off);
  assign rd_addr  = WIN_BASE + ADDR_W'(OFF_STAT);
  assign has_cnt  = cnt_nz_q;
  assign has_data = has_data_q;

  // R4: the count writes are only reached with a nonzero captured count
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_CNTL || step == ST_CNTH) |-> cnt_q != '0);

endmodule

// File: rtl/fcw_status_eval.sv
module fcw_status_eval
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] status
);

  localparam logic [DATA_W-1:0] MASK = DATA_W'(ERR_MASK);

  logic done_q, err_q;
  logic [DATA_W-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fire_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      status_q <= '0;
    end else if (fire_ready) begin
      err_q    <= |(rd_data & MASK);
      status_q <= rd_data;
    end
  end

  assign done   = done_q;
  assign err    = err_q;
  assign status = status_q;

  // R9: a reported word always carries the ready bit
  p_ready_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> status_q[READY_BIT]);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                TGT_W    = 32,
  parameter int                CNT_W    = 32,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_cmd,
  input  logic [TGT_W-1:0]  req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_has_data,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] status
);

  step_e step;
  logic  start, has_cnt, has_data, wr_fire, rd_fire, fire_ready;

  assign start      = req_valid && (step == ST_IDLE) && cmd_known(req_cmd);
  assign wr_valid   = (step != ST_IDLE) && (step != ST_POLL);
  assign rd_valid   = (step == ST_POLL);
  assign busy       = (step != ST_IDLE);
  assign wr_fire    = wr_valid && wr_ready;
  assign rd_fire    = rd_valid && rd_ready;
  assign fire_ready = rd_fire && rd_data[READY_BIT];

  fcw_step_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .has_cnt(has_cnt),
    .has_data(has_data), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .rd_is_ready(rd_data[READY_BIT]), .step(step)
  );

  fcw_word_mux #(
    .DATA_W(DATA_W), .TGT_W(TGT_W), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .load(start), .cmd_in(req_cmd),
    .addr_in(req_addr), .cnt_in(req_count), .has_data_in(req_has_data),
    .data_in(req_data), .step(step), .has_cnt(has_cnt), .has_data(has_data),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
  );

  fcw_status_eval #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .fire_ready(fire_ready), .rd_data(rd_data),
    .done(done), .err(err), .status(status)
  );

  // R7: pending write holds address and data
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R8: pending read holds its address
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R8: never a write and a read together
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));

  // R8: polling starts right after the execute write
  p_poll_after_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == WIN_BASE + ADDR_W'(OFF_EXEC)) |=> rd_valid);

  // R2: the first word of a command is the code write
  p_first_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (wr_valid && wr_addr == WIN_BASE + ADDR_W'(OFF_CMD)));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: nothing on the buses while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !rd_valid));

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

  localparam int DW = 16, TW = 32, CW = 32, AW = 16;
  localparam logic [AW-1:0] BASE = 16'h4000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_has_data;
  logic [7:0] req_cmd;
  logic [TW-1:0] req_addr;
  logic [CW-1:0] req_count;
  logic [DW-1:0] req_data;
  logic busy, wr_valid, wr_ready, rd_valid, rd_ready, done, err;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data, status;

  always #4 clk = ~clk;

  flash_cmd_seq #(.DATA_W(DW), .TGT_W(TW), .CNT_W(CW), .ADDR_W(AW), .WIN_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_count(req_count), .req_has_data(req_has_data),
    .req_data(req_data), .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .err(err), .status(status)
  );

  int total = 0, bad = 0;
  logic [AW-1:0] exp_a [0:7];
  logic [DW-1:0] exp_d [0:7];
  int exp_n = 0, w_idx = 0, polls = 0, nbusy = 0;
  logic [DW-1:0] fstat = '0;
  logic [7:0] codes [0:9] = '{8'h41, 8'hE9, 8'h20, 8'h61, 8'h62, 8'h65, 8'h98, 8'h97, 8'hC0, 8'hD0};

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a - BASE)
      16'h80: tag_of = "R2 cmd";
      16'h88, 16'h8A: tag_of = "R3 addr";
      16'h90, 16'h92: tag_of = "R4 count";
      16'h84: tag_of = "R5 data";
      default: tag_of = "R6 exec";
    endcase
  endfunction

  task automatic build_exp(input logic [7:0] c, input logic [31:0] a, input logic [31:0] n,
                           input logic hd, input logic [15:0] d);
    exp_n = 0;
    exp_a[exp_n] = BASE + 16'h80; exp_d[exp_n] = {8'h00, c}; exp_n++;
    exp_a[exp_n] = BASE + 16'h88; exp_d[exp_n] = a[15:0];   exp_n++;
    exp_a[exp_n] = BASE + 16'h8A; exp_d[exp_n] = a[31:16];  exp_n++;
    if (n != 0) begin
      exp_a[exp_n] = BASE + 16'h90; exp_d[exp_n] = n[15:0];  exp_n++;
      exp_a[exp_n] = BASE + 16'h92; exp_d[exp_n] = n[31:16]; exp_n++;
    end
    if (hd) begin
      exp_a[exp_n] = BASE + 16'h84; exp_d[exp_n] = d; exp_n++;
    end
    exp_a[exp_n] = BASE + 16'hC0; exp_d[exp_n] = 16'h0001; exp_n++;
  endtask

  // bus responder and monitor
  initial begin
    logic pend;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    pend = 1'b0; pa = '0; pd = '0;
    wr_ready = 1'b0; rd_ready = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (pend)
        chk(wr_valid && wr_addr == pa && wr_data == pd, "R7 hold", {wr_addr, wr_data}, {pa, pd});
      wr_ready = ($urandom % 4) != 0;
      rd_ready = ($urandom % 3) != 0;
      pend = wr_valid && !wr_ready;
      pa = wr_addr; pd = wr_data;
      if (wr_valid && wr_ready) begin
        if (w_idx < exp_n)
          chk(wr_addr == exp_a[w_idx] && wr_data == exp_d[w_idx], tag_of(exp_a[w_idx]),
              {wr_addr, wr_data}, {exp_a[w_idx], exp_d[w_idx]});
        else
          chk(1'b0, "R6 extra write", {wr_addr, wr_data}, 32'h0);
        w_idx++;
      end
      if (rd_valid && rd_ready) begin
        chk(rd_addr == BASE + 16'hCC, "R8 read addr", {16'h0, rd_addr}, {16'h0, BASE + 16'hCC});
        if (polls < nbusy) rd_data = 16'($urandom) & 16'hFF7F;
        else               rd_data = fstat | 16'h0080;
        polls++;
      end
    end
  end

  task automatic run_cmd(input logic [7:0] c, input logic [31:0] a, input logic [31:0] n,
                         input logic hd, input logic [15:0] d, input int nb, input logic [15:0] fs,
                         input logic poke);
    logic [15:0] es;
    int k;
    build_exp(c, a, n, hd, d);
    nbusy = nb; fstat = fs; polls = 0; w_idx = 0;
    es = fs | 16'h0080;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_count = n;
    req_has_data = hd; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!done) begin
      @(negedge clk);
      k++;
      if (poke && k == 2) begin
        chk(busy, "R10 busy", {31'h0, busy}, 32'h1);
        req_valid = 1'b1; req_cmd = 8'h20; req_addr = ~a; req_count = 32'h5;
        req_has_data = ~hd; req_data = ~d;
      end
      if (k == 3) req_valid = 1'b0;
    end
    chk(status == es, "R9 status", {16'h0, status}, {16'h0, es});
    chk(err == ((es & 16'h133A) != 0), "R9 err", {31'h0, err}, {31'h0, ((es & 16'h133A) != 0)});
    @(negedge clk);
    chk(!done, "R9 pulse", {31'h0, done}, 32'h0);
    chk(w_idx == exp_n, "R6 write count", w_idx, exp_n);
    chk(polls == nb + 1, "R8 poll count", polls, nb + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0;
    req_count = '0; req_has_data = 1'b0; req_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !wr_valid && !rd_valid && !done, "R1 reset",
        {28'h0, busy, wr_valid, rd_valid, done}, 32'h0);

    // R4 zero count skip, R5 no data
    run_cmd(8'h20, 32'h1234_5678, 32'h0, 1'b0, 16'h0, 0, 16'h0000, 1'b0);
    // R4 count and R5 data present, error bit in status
    run_cmd(8'hE9, 32'hDEAD_BEEF, 32'h0003_0040, 1'b1, 16'hA5A5, 3, 16'h0010, 1'b0);
    // R3 high part zero, data without count, masked non-error bit
    run_cmd(8'h41, 32'h0000_00FF, 32'h0, 1'b1, 16'h5A5A, 1, 16'h0004, 1'b0);
    // R10 request while busy ignored
    run_cmd(8'h61, 32'h8000_0001, 32'h1, 1'b0, 16'h0, 2, 16'h1000, 1'b1);

    // R10 unknown code ignored
    w_idx = 0; exp_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 8'h55;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!busy, "R10 unknown busy", {31'h0, busy}, 32'h0);
    repeat (8) @(negedge clk);
    chk(w_idx == 0 && !busy, "R10 unknown writes", w_idx, 0);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] n;
      n = (($urandom % 3) == 0) ? 32'h0 : 32'($urandom);
      run_cmd(codes[$urandom % 10], 32'($urandom), n, 1'($urandom), 16'($urandom),
              int'($urandom % 6), 16'($urandom) & 16'hFF7F, (i % 5) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule